// File: doc/BRIEF.md
# Range-Compressed Branch Target Buffer

This block is a set-associative branch target buffer for an instruction fetch front end. Fetch logic presents a fetch address on the lookup port, ahead of decode. One cycle later the buffer reports whether a known branch sits at that address, whether it is predicted taken, and where it goes. When a branch resolves, the update port installs the branch or refreshes an existing entry with its actual target and direction.

To save storage, no entry holds a full target address. Ways fall into two classes. Narrow ways keep only the low `NARROW_BITS` bits of the target. Wide ways keep the low `WIDE_BITS` bits. In both classes the remaining upper bits are assumed equal to the branch address, and they are spliced back from the lookup address when a prediction is formed. On update, the distance between branch and target decides which class may hold the entry. A target too far away for either class is not cached. Each class runs its own per-set replacement state, so a narrow allocation never evicts a wide entry and a wide allocation never evicts a narrow one.

The defaults are sized for quick elaboration (64 sets of three narrow and two wide ways). The set count, way counts, stored widths and tag width are all parameters, and the same structure scales to 2048 sets of five ways.

Top module: `btb_range`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears every valid bit and all replacement state. Every lookup after reset misses until a new update installs an entry, and `pr_valid` and `pr_hit` read 0 in the cycle after a reset edge.
- R2: A lookup presented with `lk_valid` high at a rising edge produces its result on `pr_valid`/`pr_hit`/`pr_taken`/`pr_target` after that edge, valid until the next edge. `pr_hit` is never 1 without a lookup at the previous edge.
- R3: On a miss, `pr_hit`, `pr_taken` and `pr_target` are all 0.
- R4: On a hit, the predicted target is the lookup address with its bits below the class width (`NARROW_BITS` for a narrow way, `WIDE_BITS` for a wide way) replaced by the stored target bits.
- R5: Set index is `addr[INDEX_LSB +: log2(SETS)]` and the partial tag is the next `TAG_W` address bits. A hit needs a valid entry with equal index and tag, so addresses that differ only outside these fields alias to the same entry.
- R6: On update with no existing entry, the branch is installed in a narrow way when branch and target agree in every bit at or above `NARROW_BITS`. Otherwise it goes in a wide way when they agree at or above `WIDE_BITS`. Otherwise nothing is installed.
- R7: A newly installed entry starts its 2-bit counter at 2 (binary 10) when the resolved branch was taken and at 1 (binary 01) when not taken. A hit predicts taken exactly when the counter's upper bit is 1.
- R8: An update that hits an entry whose class can hold the new target rewrites the target in place and steps the counter by one toward 3 when taken, or toward 0 when not taken. It saturates at 0 and 3.
- R9: An update that hits an entry whose class cannot hold the new target invalidates it. The branch is then installed per R6 into the other class if that class fits, and is left uncached otherwise.
- R10: Victim choice within a class and set: the lowest invalid way. If none is invalid, the lowest way whose recent-use mark is clear. Installing or refreshing a way sets its mark, and when that would set every mark in the row, all the others are cleared.
- R11: Narrow and wide ways are replaced independently. Filling the narrow ways of a set never evicts a wide entry in that set.
- R12: When an update and a lookup reach the same set in the same cycle, the lookup sees the contents from before the update. The update is visible to lookups from the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_addr | input | ADDR_W | Fetch address to look up |
| pr_valid | output | 1 | Result of the previous cycle's lookup is present |
| pr_hit | output | 1 | A matching entry was found |
| pr_taken | output | 1 | Predicted direction of the matching entry |
| pr_target | output | ADDR_W | Rebuilt predicted target, 0 on a miss |
| up_valid | input | 1 | Resolved branch update this cycle |
| up_addr | input | ADDR_W | Address of the resolved branch |
| up_target | input | ADDR_W | Actual target of the resolved branch |
| up_taken | input | 1 | Actual direction of the resolved branch |

## Verification
The bench builds the buffer with a 40-bit address, 16 sets, a 12-bit tag, three narrow ways of 20 target bits and two wide ways of 30 target bits. With only four index bits and the tag sitting just above them, a set can be filled and overflowed with a handful of hand-picked addresses. That exercises the recent-use victim rule, class isolation and the reclassification of an entry whose target moved. The 40-bit address leaves room above bit 30 to build targets that fit neither class, and lookup addresses that alias a stored entry through bits outside index and tag, so the splicing of upper bits can be observed directly at `pr_target`.

// File: rtl/btb_pkg.sv
`timescale 1ns/1ps
package btb_pkg;

   // Command a way class receives from the top for the update port
   typedef enum logic [1:0] {
      CLS_IDLE    = 2'd0,
      CLS_REFRESH = 2'd1,
      CLS_DROP    = 2'd2,
      CLS_ALLOC   = 2'd3
   } cls_op_e;

   // Starting counter for a freshly installed branch
   function automatic logic [1:0] ctr_seed(input logic taken);
      return taken ? 2'b10 : 2'b01;
   endfunction

   // Saturating step of the 2-bit direction counter
   function automatic logic [1:0] ctr_next(input logic [1:0] cur, input logic taken);
      if (taken)
         return (cur == 2'b11) ? cur : cur + 2'd1;
      else
         return (cur == 2'b00) ? cur : cur - 2'd1;
   endfunction

endpackage

// File: rtl/btb_first_one.sv
`timescale 1ns/1ps
module btb_first_one #(
   parameter int W = 4
) (
   input  logic [W-1:0] req,
   output logic [W-1:0] grant
);

   initial begin
      if (W < 1) $fatal(1, "btb_first_one: W must be at least 1");
   end

   always_comb begin
      logic seen;
      seen  = 1'b0;
      grant = '0;
      for (int i = 0; i < W; i++) begin
         if (req[i] && !seen) begin
            grant[i] = 1'b1;
            seen     = 1'b1;
         end
      end
   end

endmodule

// File: rtl/btb_plru_pick.sv
`timescale 1ns/1ps
module btb_plru_pick #(
   parameter int WAYS = 3
) (
   input  logic [WAYS-1:0] row_vld,
   input  logic [WAYS-1:0] row_mru,
   output logic [WAYS-1:0] victim
);

   logic [WAYS-1:0] cand;
   logic [WAYS-1:0] pick;

   // Invalid ways first; once the row is full, any way without a recent-use mark
   assign cand = (&row_vld) ? ~row_mru : ~row_vld;

   btb_first_one #(.W(WAYS)) first_i (
      .req   (cand),
      .grant (pick)
   );

   // A single-way row keeps its only mark set, so fall back to way 0
   assign victim = (|cand) ? pick : WAYS'(1);

endmodule

// File: rtl/btb_way_class.sv
`timescale 1ns/1ps
module btb_way_class
   import btb_pkg::*;
#(
   parameter int WAYS  = 3,
   parameter int SETS  = 64,
   parameter int IDX_W = 6,
   parameter int TAG_W = 12,
   parameter int TGT_W = 20
) (
   input  logic             clk,
   input  logic             rst,
   // lookup side
   input  logic             rd_en,
   input  logic [IDX_W-1:0] rd_idx,
   input  logic [TAG_W-1:0] rd_tag,
   output logic             rd_hit,
   output logic [TGT_W-1:0] rd_tgt,
   output logic [1:0]       rd_ctr,
   // update side
   input  logic [IDX_W-1:0] up_idx,
   input  logic [TAG_W-1:0] up_tag,
   output logic             up_hit,
   output logic [1:0]       up_ctr,
   input  cls_op_e          up_op,
   input  logic [TGT_W-1:0] up_tgt,
   input  logic [1:0]       up_ctr_new
);

   initial begin
      if (WAYS < 1)             $fatal(1, "btb_way_class: WAYS must be at least 1");
      if ((1 << IDX_W) != SETS) $fatal(1, "btb_way_class: SETS must equal 2**IDX_W");
   end

   // storage
   logic [WAYS-1:0]  vld_q [SETS];
   logic [WAYS-1:0]  mru_q [SETS];
   logic [TAG_W-1:0] tag_q [SETS][WAYS];
   logic [TGT_W-1:0] tgt_q [SETS][WAYS];
   logic [1:0]       ctr_q [SETS][WAYS];

   // lookup snapshot, taken at the edge before any same-cycle write lands
   logic [WAYS-1:0]  snap_vld_q;
   logic [TAG_W-1:0] snap_tag_q [WAYS];
   logic [TGT_W-1:0] snap_tgt_q [WAYS];
   logic [1:0]       snap_ctr_q [WAYS];
   logic [TAG_W-1:0] want_tag_q;

   always_ff @(posedge clk) begin
      if (rd_en) begin
         snap_vld_q <= vld_q[rd_idx];
         want_tag_q <= rd_tag;
         for (int w = 0; w < WAYS; w++) begin
            snap_tag_q[w] <= tag_q[rd_idx][w];
            snap_tgt_q[w] <= tgt_q[rd_idx][w];
            snap_ctr_q[w] <= ctr_q[rd_idx][w];
         end
      end
   end

   logic [WAYS-1:0] rd_match, rd_sel;
   logic [WAYS-1:0] up_match, up_sel;
   logic [WAYS-1:0] up_row_vld, up_row_mru;

   assign up_row_vld = vld_q[up_idx];
   assign up_row_mru = mru_q[up_idx];

   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign rd_match[w] = snap_vld_q[w] && (snap_tag_q[w] == want_tag_q);
      assign up_match[w] = up_row_vld[w] && (tag_q[up_idx][w] == up_tag);
   end

   btb_first_one #(.W(WAYS)) rd_first_i (.req(rd_match), .grant(rd_sel));
   btb_first_one #(.W(WAYS)) up_first_i (.req(up_match), .grant(up_sel));

   assign rd_hit = |rd_match;
   assign up_hit = |up_match;

   always_comb begin
      rd_tgt = '0;
      rd_ctr = '0;
      up_ctr = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (rd_sel[w]) begin
            rd_tgt = rd_tgt | snap_tgt_q[w];
            rd_ctr = rd_ctr | snap_ctr_q[w];
         end
         if (up_sel[w]) up_ctr = up_ctr | ctr_q[up_idx][w];
      end
   end

   // replacement
   logic [WAYS-1:0] victim, wr_sel, touched, mru_next;

   btb_plru_pick #(.WAYS(WAYS)) plru_i (
      .row_vld (up_row_vld),
      .row_mru (up_row_mru),
      .victim  (victim)
   );

   assign wr_sel   = (up_op == CLS_ALLOC) ? victim : up_sel;
   assign touched  = up_row_mru | wr_sel;
   assign mru_next = (&touched) ? wr_sel : touched;

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int s = 0; s < SETS; s++) begin
            vld_q[s] <= '0;
            mru_q[s] <= '0;
         end
      end else begin
         case (up_op)
            CLS_REFRESH: mru_q[up_idx] <= mru_next;
            CLS_DROP:    vld_q[up_idx] <= up_row_vld & ~wr_sel;
            CLS_ALLOC: begin
               vld_q[up_idx] <= up_row_vld | wr_sel;
               mru_q[up_idx] <= mru_next;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      for (int w = 0; w < WAYS; w++) begin
         if (wr_sel[w] && (up_op == CLS_REFRESH || up_op == CLS_ALLOC)) begin
            tgt_q[up_idx][w] <= up_tgt;
            ctr_q[up_idx][w] <= up_ctr_new;
            if (up_op == CLS_ALLOC) tag_q[up_idx][w] <= up_tag;
         end
      end
   end

endmodule

// File: rtl/btb_range.sv
`timescale 1ns/1ps
module btb_range
   import btb_pkg::*;
#(
   parameter int ADDR_W      = 40,
   parameter int SETS        = 64,
   parameter int INDEX_LSB   = 1,
   parameter int TAG_W       = 12,
   parameter int NARROW_WAYS = 3,
   parameter int WIDE_WAYS   = 2,
   parameter int NARROW_BITS = 20,
   parameter int WIDE_BITS   = 30
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              lk_valid,
   input  logic [ADDR_W-1:0] lk_addr,
   output logic              pr_valid,
   output logic              pr_hit,
   output logic              pr_taken,
   output logic [ADDR_W-1:0] pr_target,
   input  logic              up_valid,
   input  logic [ADDR_W-1:0] up_addr,
   input  logic [ADDR_W-1:0] up_target,
   input  logic              up_taken
);

   localparam int IDX_W   = $clog2(SETS);
   localparam int TAG_LSB = INDEX_LSB + IDX_W;

   initial begin
      if ((1 << IDX_W) != SETS)        $fatal(1, "btb_range: SETS must be a power of two");
      if (NARROW_BITS >= WIDE_BITS)    $fatal(1, "btb_range: narrow width must be below wide width");
      if (WIDE_BITS > ADDR_W)          $fatal(1, "btb_range: wide width exceeds address width");
      if (TAG_LSB + TAG_W > ADDR_W)    $fatal(1, "btb_range: index and tag exceed the address");
      if (NARROW_WAYS < 1 || WIDE_WAYS < 1) $fatal(1, "btb_range: each class needs a way");
   end

   // field extraction
   logic [IDX_W-1:0] lk_idx, up_idx;
   logic [TAG_W-1:0] lk_tag, up_tag;

   assign lk_idx = lk_addr[INDEX_LSB +: IDX_W];
   assign lk_tag = lk_addr[TAG_LSB +: TAG_W];
   assign up_idx = up_addr[INDEX_LSB +: IDX_W];
   assign up_tag = up_addr[TAG_LSB +: TAG_W];

   logic unused_addr_bits;
   assign unused_addr_bits = ^{lk_addr, up_addr};

   // lookup pipeline register
   logic                        pr_valid_q;
   logic [ADDR_W-1:NARROW_BITS] lk_hi_q;

   always_ff @(posedge clk) begin
      if (rst) pr_valid_q <= 1'b0;
      else     pr_valid_q <= lk_valid;
   end

   always_ff @(posedge clk) begin
      if (lk_valid) lk_hi_q <= lk_addr[ADDR_W-1:NARROW_BITS];
   end

   // class reach tests and target rebuild
   logic                   fit_n, fit_w;
   logic                   n_rd_hit, w_rd_hit, n_up_hit, w_up_hit;
   logic [NARROW_BITS-1:0] n_rd_tgt;
   logic [WIDE_BITS-1:0]   w_rd_tgt;
   logic [1:0]             n_rd_ctr, w_rd_ctr, n_up_ctr, w_up_ctr;
   logic [ADDR_W-1:0]      splice_n, splice_w;

   assign fit_n    = (up_addr[ADDR_W-1:NARROW_BITS] == up_target[ADDR_W-1:NARROW_BITS]);
   assign splice_n = {lk_hi_q, n_rd_tgt};

   if (WIDE_BITS < ADDR_W) begin : g_wide_part
      assign fit_w    = (up_addr[ADDR_W-1:WIDE_BITS] == up_target[ADDR_W-1:WIDE_BITS]);
      assign splice_w = {lk_hi_q[ADDR_W-1:WIDE_BITS], w_rd_tgt};
   end else begin : g_wide_full
      assign fit_w    = 1'b1;
      assign splice_w = w_rd_tgt;
   end

   // update decision
   cls_op_e    n_op, w_op;
   logic [1:0] n_ctr_new, w_ctr_new;

   always_comb begin
      n_op      = CLS_IDLE;
      w_op      = CLS_IDLE;
      n_ctr_new = ctr_seed(up_taken);
      w_ctr_new = ctr_seed(up_taken);
      if (up_valid && !rst) begin
         if (n_up_hit) begin
            if (fit_n) begin
               n_op      = CLS_REFRESH;
               n_ctr_new = ctr_next(n_up_ctr, up_taken);
            end else begin
               n_op = CLS_DROP;
               if (fit_w) w_op = CLS_ALLOC;
            end
         end else if (w_up_hit) begin
            if (fit_w) begin
               w_op      = CLS_REFRESH;
               w_ctr_new = ctr_next(w_up_ctr, up_taken);
            end else begin
               w_op = CLS_DROP;
            end
         end else if (fit_n) begin
            n_op = CLS_ALLOC;
         end else if (fit_w) begin
            w_op = CLS_ALLOC;
         end
      end
   end

   btb_way_class #(
      .WAYS(NARROW_WAYS), .SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W), .TGT_W(NARROW_BITS)
   ) narrow_i (
      .clk        (clk),
      .rst        (rst),
      .rd_en      (lk_valid),
      .rd_idx     (lk_idx),
      .rd_tag     (lk_tag),
      .rd_hit     (n_rd_hit),
      .rd_tgt     (n_rd_tgt),
      .rd_ctr     (n_rd_ctr),
      .up_idx     (up_idx),
      .up_tag     (up_tag),
      .up_hit     (n_up_hit),
      .up_ctr     (n_up_ctr),
      .up_op      (n_op),
      .up_tgt     (up_target[NARROW_BITS-1:0]),
      .up_ctr_new (n_ctr_new)
   );

   btb_way_class #(
      .WAYS(WIDE_WAYS), .SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W), .TGT_W(WIDE_BITS)
   ) wide_i (
      .clk        (clk),
      .rst        (rst),
      .rd_en      (lk_valid),
      .rd_idx     (lk_idx),
      .rd_tag     (lk_tag),
      .rd_hit     (w_rd_hit),
      .rd_tgt     (w_rd_tgt),
      .rd_ctr     (w_rd_ctr),
      .up_idx     (up_idx),
      .up_tag     (up_tag),
      .up_hit     (w_up_hit),
      .up_ctr     (w_up_ctr),
      .up_op      (w_op),
      .up_tgt     (up_target[WIDE_BITS-1:0]),
      .up_ctr_new (w_ctr_new)
   );

   // result merge, narrow class first
   always_comb begin
      pr_hit    = 1'b0;
      pr_taken  = 1'b0;
      pr_target = '0;
      if (pr_valid_q) begin
         if (n_rd_hit) begin
            pr_hit    = 1'b1;
            pr_taken  = n_rd_ctr[1];
            pr_target = splice_n;
         end else if (w_rd_hit) begin
            pr_hit    = 1'b1;
            pr_taken  = w_rd_ctr[1];
            pr_target = splice_w;
         end
      end
   end

   assign pr_valid = pr_valid_q;

endmodule

// File: rtl/btb_range_chk.sv
`timescale 1ns/1ps
module btb_range_chk #(
   parameter int ADDR_W    = 40,
   parameter int WIDE_BITS = 30
) (
   input logic              clk,
   input logic              rst,
   input logic              lk_valid,
   input logic [ADDR_W-1:0] lk_addr,
   input logic              pr_valid,
   input logic              pr_hit,
   input logic              pr_taken,
   input logic [ADDR_W-1:0] pr_target
);

   // R1
   reset_quiets_result_chk: assert property (@(posedge clk)
      rst |=> (!pr_valid && !pr_hit));

   // R2
   hit_follows_request_chk: assert property (@(posedge clk) disable iff (rst)
      pr_hit |-> $past(lk_valid));

   // R3
   miss_outputs_zero_chk: assert property (@(posedge clk) disable iff (rst)
      !pr_hit |-> (!pr_taken && pr_target == '0));

   // R7
   taken_needs_hit_chk: assert property (@(posedge clk) disable iff (rst)
      pr_taken |-> pr_hit);

   if (WIDE_BITS < ADDR_W) begin : g_hi
      logic unused_low_bits;
      assign unused_low_bits = ^lk_addr[WIDE_BITS-1:0];
      // R4
      upper_bits_spliced_chk: assert property (@(posedge clk) disable iff (rst)
         pr_hit |-> (pr_target[ADDR_W-1:WIDE_BITS] == $past(lk_addr[ADDR_W-1:WIDE_BITS])));
   end else begin : g_no_hi
      logic unused_all_bits;
      assign unused_all_bits = ^lk_addr;
   end

endmodule

bind btb_range btb_range_chk #(.ADDR_W(ADDR_W), .WIDE_BITS(WIDE_BITS)) chk_i (
   .clk       (clk),
   .rst       (rst),
   .lk_valid  (lk_valid),
   .lk_addr   (lk_addr),
   .pr_valid  (pr_valid),
   .pr_hit    (pr_hit),
   .pr_taken  (pr_taken),
   .pr_target (pr_target)
);

// File: tb/btb_range_tb_top.sv
`timescale 1ns/1ps
module btb_range_tb_top;

   localparam int AW = 40;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          lk_valid = 1'b0;
   logic [AW-1:0] lk_addr = '0;
   logic          pr_valid, pr_hit, pr_taken;
   logic [AW-1:0] pr_target;
   logic          up_valid = 1'b0;
   logic [AW-1:0] up_addr = '0;
   logic [AW-1:0] up_target = '0;
   logic          up_taken = 1'b0;

   always #2 clk = ~clk;

   btb_range #(
      .ADDR_W(AW), .SETS(16), .INDEX_LSB(1), .TAG_W(12),
      .NARROW_WAYS(3), .WIDE_WAYS(2), .NARROW_BITS(20), .WIDE_BITS(30)
   ) dut_i (
      .clk(clk), .rst(rst),
      .lk_valid(lk_valid), .lk_addr(lk_addr),
      .pr_valid(pr_valid), .pr_hit(pr_hit), .pr_taken(pr_taken), .pr_target(pr_target),
      .up_valid(up_valid), .up_addr(up_addr), .up_target(up_target), .up_taken(up_taken)
   );

   typedef struct {
      logic          hit;
      logic          taken;
      logic [AW-1:0] tgt;
      string         req;
   } exp_t;

   exp_t sb_q[$];
   int   n_vec  = 0;
   int   n_fail = 0;

   // index in bits 4:1, tag in bits 16:5
   function automatic logic [AW-1:0] mk(input int hi, input int tg, input int st);
      return (AW'(hi) << 17) | (AW'(tg) << 5) | (AW'(st) << 1);
   endfunction

   task automatic look(input logic [AW-1:0] a, input logic eh, input logic et,
                       input logic [AW-1:0] etg, input string r);
      exp_t e;
      e.hit = eh; e.taken = et; e.tgt = etg; e.req = r;
      sb_q.push_back(e);
      lk_valid = 1'b1;
      lk_addr  = a;
      @(posedge clk); #1;
      lk_valid = 1'b0;
   endtask

   task automatic upd(input logic [AW-1:0] a, input logic [AW-1:0] t, input logic tk);
      up_valid = 1'b1; up_addr = a; up_target = t; up_taken = tk;
      @(posedge clk); #1;
      up_valid = 1'b0;
   endtask

   task automatic upd_and_look(input logic [AW-1:0] a, input logic [AW-1:0] t, input logic tk,
                               input logic eh, input logic et, input logic [AW-1:0] etg,
                               input string r);
      exp_t e;
      e.hit = eh; e.taken = et; e.tgt = etg; e.req = r;
      sb_q.push_back(e);
      up_valid = 1'b1; up_addr = a; up_target = t; up_taken = tk;
      lk_valid = 1'b1; lk_addr = a;
      @(posedge clk); #1;
      up_valid = 1'b0;
      lk_valid = 1'b0;
   endtask

   task automatic do_reset();
      rst = 1'b1;
      repeat (2) @(posedge clk);
      #1 rst = 1'b0;
   endtask

   // monitor: compare each produced result against the oldest expectation
   always @(negedge clk) begin
      if (pr_valid) begin
         n_vec++;
         if (sb_q.size() == 0) begin
            n_fail++;
            $display("FAIL R2: result with no request, hit=%0b expected none", pr_hit);
         end else begin
            exp_t e;
            e = sb_q.pop_front();
            if (pr_hit !== e.hit || pr_taken !== e.taken || pr_target !== e.tgt) begin
               n_fail++;
               $display("FAIL %s: hit=%0b taken=%0b tgt=%h expected hit=%0b taken=%0b tgt=%h",
                        e.req, pr_hit, pr_taken, pr_target, e.hit, e.taken, e.tgt);
            end
         end
      end
   end

   initial begin
      #400000;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

   initial begin
      logic [AW-1:0] a_br, a_t, b_br, c_br, d_br, e_br, w5;
      a_br = mk(0, 1, 1);
      a_t  = a_br + 40'h100;
      b_br = mk(0, 2, 2);
      c_br = mk(0, 3, 3);
      d_br = mk(0, 7, 6);
      e_br = mk(0, 8, 7);
      w5   = mk(0, 9, 5);

      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      @(negedge clk);
      n_vec++;
      if (pr_valid !== 1'b0 || pr_hit !== 1'b0) begin
         n_fail++;
         $display("FAIL R1: valid=%0b hit=%0b expected 0 0 after reset", pr_valid, pr_hit);
      end
      @(posedge clk); #1;

      // R1 / R3: empty buffer misses with zero outputs
      look(a_br, 1'b0, 1'b0, '0, "R3");

      // R6 narrow install, R7 taken seed, R4 rebuild
      upd(a_br, a_t, 1'b1);
      look(a_br, 1'b1, 1'b1, a_t, "R6");

      // R8 counter walk: 10 ->01 ->00 ->00 ->01 ->10 ->11 ->11 ->10
      upd(a_br, a_t, 1'b0);
      look(a_br, 1'b1, 1'b0, a_t, "R8");
      upd(a_br, a_t, 1'b0);
      upd(a_br, a_t, 1'b0);
      upd(a_br, a_t, 1'b1);
      look(a_br, 1'b1, 1'b0, a_t, "R8");
      upd(a_br, a_t, 1'b1);
      look(a_br, 1'b1, 1'b1, a_t, "R8");
      upd(a_br, a_t, 1'b1);
      upd(a_br, a_t, 1'b1);
      upd(a_br, a_t, 1'b0);
      look(a_br, 1'b1, 1'b1, a_t, "R8");

      // R5 alias through bit 38, R4 upper bits from the lookup address
      look(a_br | (40'h1 << 38), 1'b1, 1'b1, a_t | (40'h1 << 38), "R5");

      // R6 wide install
      upd(b_br, b_br ^ (40'h1 << 24), 1'b1);
      look(b_br, 1'b1, 1'b1, b_br ^ (40'h1 << 24), "R6");
      // R8 near target refreshed in place in the wide way
      upd(b_br, b_br + 40'h4, 1'b1);
      look(b_br, 1'b1, 1'b1, b_br + 40'h4, "R8");

      // R6 out of range: not installed
      upd(c_br, c_br ^ (40'h1 << 35), 1'b1);
      look(c_br, 1'b0, 1'b0, '0, "R6");

      // R7 not-taken seed
      upd(e_br, e_br + 40'h8, 1'b0);
      look(e_br, 1'b1, 1'b0, e_br + 40'h8, "R7");

      // R9 narrow entry moved to wide, then dropped when out of range
      upd(a_br, a_br ^ (40'h1 << 22), 1'b1);
      look(a_br, 1'b1, 1'b1, a_br ^ (40'h1 << 22), "R9");
      upd(a_br, a_br ^ (40'h1 << 34), 1'b1);
      look(a_br, 1'b0, 1'b0, '0, "R9");

      // R10 / R11 replacement in set 5
      upd(w5, w5 ^ (40'h1 << 25), 1'b1);
      for (int k = 1; k <= 4; k++) upd(mk(0, k, 5), mk(0, k, 5) + 40'h10, 1'b1);
      look(mk(0, 1, 5), 1'b0, 1'b0, '0, "R10");
      look(mk(0, 4, 5), 1'b1, 1'b1, mk(0, 4, 5) + 40'h10, "R10");
      upd(mk(0, 2, 5), mk(0, 2, 5) + 40'h10, 1'b1);
      upd(mk(0, 5, 5), mk(0, 5, 5) + 40'h10, 1'b1);
      look(mk(0, 4, 5), 1'b0, 1'b0, '0, "R10");
      look(mk(0, 2, 5), 1'b1, 1'b1, mk(0, 2, 5) + 40'h10, "R10");
      look(mk(0, 3, 5), 1'b1, 1'b1, mk(0, 3, 5) + 40'h10, "R10");
      look(mk(0, 5, 5), 1'b1, 1'b1, mk(0, 5, 5) + 40'h10, "R10");
      look(w5, 1'b1, 1'b1, w5 ^ (40'h1 << 25), "R11");

      // R12 same-cycle update and lookup
      upd_and_look(d_br, d_br + 40'h40, 1'b1, 1'b0, 1'b0, '0, "R12");
      look(d_br, 1'b1, 1'b1, d_br + 40'h40, "R12");

      // R1 reset mid-run clears installed entries
      do_reset();
      look(b_br, 1'b0, 1'b0, '0, "R1");
      look(w5, 1'b0, 1'b0, '0, "R1");

      repeat (3) @(posedge clk);
      n_vec++;
      if (sb_q.size() != 0) begin
         n_fail++;
         $display("FAIL R2: %0d results missing, expected 0", sb_q.size());
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

endmodule